// File: doc/BRIEF.md
# Debug Address Comparator Bank

This block sits beside the fetch and load/store stages of a small 32-bit CPU and compares their addresses against a set of programmed debug addresses. It holds a bank of instruction breakpoint slots, which are compared with the fetch program counter, and a bank of data watchpoint slots, which are compared with the byte address of each data access. Each watchpoint slot carries an access kind that chooses whether reads, writes or both are trapped. Each slot also has a valid bit.

A single write port programs the slots. It carries a bank select, a slot index, an address, a kind code and a clear flag. A data access that hits an active watchpoint is blocked in the same cycle, so it never reaches memory or the register file. One cycle after a hit, the block raises a registered breakpoint or watchpoint request, together with a mask of the slots that hit. The exception logic takes these requests. When a breakpoint and a watchpoint hit together, only the breakpoint is reported, because the fetch comes before its own data access.

Top module: `dbg_match_unit`

## Requirements
- R1: After reset every slot is empty. No request, mask bit or block is raised for any address, including address 0.
- R2: When `fetch_vld` is high and `fetch_pc` equals the address of a valid breakpoint slot, `bp_req` is high in the next cycle. `bp_mask` has bit i set for each breakpoint slot i that matched. When `fetch_vld` is low, nothing fires.
- R3: Watchpoint kind codes are 2'b01 for reads only (`mem_wr`=0), 2'b10 for writes only (`mem_wr`=1) and 2'b11 for both directions. An access in a direction the kind excludes does not hit.
- R4: A watchpoint programmed with kind 2'b00 becomes empty and never hits, whatever address it holds.
- R5: `mem_block` is high in the same cycle as a valid data access (`mem_vld`=1) that hits an active watchpoint. It is low in every other case, including a matching address while `mem_vld`=0.
- R6: Matching compares the full byte address exactly. A neighbouring byte or a difference in the top bit does not hit.
- R7: A write with `cfg_clr`=1 empties the selected slot (`cfg_wp`=0 for breakpoints, 1 for watchpoints). Clearing a slot that is already empty changes nothing, and other slots keep hitting.
- R8: When a breakpoint and a watchpoint hit in the same cycle, only `bp_req` is raised the next cycle. `wp_req` stays low and `wp_mask` is zero, while `mem_block` still stops the access.
- R9: `wp_req` is high one cycle after any watchpoint hit, and `wp_mask` shows every slot that hit. With no hit, both are low.
- R10: Programming an occupied slot replaces its address and kind, so the old address no longer hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Programming strobe |
| cfg_clr | input | 1 | With `cfg_we`, empties the slot instead of loading it |
| cfg_wp | input | 1 | Bank select: 0 breakpoint, 1 watchpoint |
| cfg_idx | input | IDX_W | Slot index |
| cfg_addr | input | ADDR_W | Address to load |
| cfg_kind | input | 2 | Watchpoint kind code (ignored for breakpoints) |
| fetch_vld | input | 1 | Fetch address valid |
| fetch_pc | input | ADDR_W | Fetch program counter |
| mem_vld | input | 1 | Data access valid |
| mem_wr | input | 1 | Data access is a store |
| mem_addr | input | ADDR_W | Data byte address |
| mem_block | output | 1 | Stop the current data access |
| bp_req | output | 1 | Breakpoint exception request |
| bp_mask | output | NUM_BP | Breakpoint slots that hit |
| wp_req | output | 1 | Watchpoint exception request |
| wp_mask | output | NUM_WP | Watchpoint slots that hit |

## Verification
The hardest case to reach is a breakpoint and a watchpoint hitting in the same cycle. It needs a breakpoint on the fetch address and a watchpoint of a matching kind on the data address, both presented together. The stimulus programs both banks first and then drives both buses in one cycle. It also checks that the block still stops the access while the watchpoint request is suppressed. A second hard case is two watchpoint slots on one address with different kinds. It is reached by loading duplicate addresses and sweeping the access direction.

// File: rtl/dbg_match_pkg.sv
package dbg_match_pkg;

    typedef enum logic [1:0] {
        WK_OFF = 2'b00,
        WK_RD  = 2'b01,
        WK_WR  = 2'b10,
        WK_RW  = 2'b11
    } wp_kind_e;

    function automatic logic kind_allows(wp_kind_e k, logic is_wr);
        case (k)
            WK_RD:   return !is_wr;
            WK_WR:   return is_wr;
            WK_RW:   return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/dbg_bp_bank.sv
module dbg_bp_bank #(
    parameter int ADDR_W = 32,
    parameter int NUM    = 4,
    parameter int IDX_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              clr_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              pc_vld,
    input  logic [ADDR_W-1:0] pc,
    output logic [NUM-1:0]    hit_vec
);
    typedef struct packed {
        logic [NUM-1:0]             vld;
        logic [NUM-1:0][ADDR_W-1:0] addr;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM; i++) begin
            if (wr_en && idx == IDX_W'(i)) begin
                if (clr_en) begin
                    st_d.vld[i] = 1'b0;
                end else begin
                    st_d.vld[i]  = 1'b1;
                    st_d.addr[i] = wr_addr;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar g = 0; g < NUM; g++) begin : g_cmp
        assign hit_vec[g] = pc_vld && st_q.vld[g] && (st_q.addr[g] == pc);
    end
endmodule

// File: rtl/dbg_wp_bank.sv
module dbg_wp_bank
    import dbg_match_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int NUM    = 4,
    parameter int IDX_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              clr_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [1:0]        wr_kind,
    input  logic              acc_vld,
    input  logic              acc_wr,
    input  logic [ADDR_W-1:0] acc_addr,
    output logic [NUM-1:0]    hit_vec
);
    typedef struct packed {
        logic [NUM-1:0]             vld;
        logic [NUM-1:0][1:0]        kind;
        logic [NUM-1:0][ADDR_W-1:0] addr;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM; i++) begin
            if (wr_en && idx == IDX_W'(i)) begin
                if (clr_en) begin
                    st_d.vld[i]  = 1'b0;
                    st_d.kind[i] = WK_OFF;
                end else begin
                    st_d.vld[i]  = (wp_kind_e'(wr_kind) != WK_OFF);
                    st_d.kind[i] = wr_kind;
                    st_d.addr[i] = wr_addr;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar g = 0; g < NUM; g++) begin : g_cmp
        assign hit_vec[g] = acc_vld && st_q.vld[g]
                          && (st_q.addr[g] == acc_addr)
                          && kind_allows(wp_kind_e'(st_q.kind[g]), acc_wr);
    end
endmodule

// File: rtl/dbg_hit_arb.sv
module dbg_hit_arb #(
    parameter int NUM_BP = 4,
    parameter int NUM_WP = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_BP-1:0] bp_vec,
    input  logic [NUM_WP-1:0] wp_vec,
    output logic              bp_req,
    output logic [NUM_BP-1:0] bp_mask,
    output logic              wp_req,
    output logic [NUM_WP-1:0] wp_mask
);
    typedef struct packed {
        logic              bp_req;
        logic [NUM_BP-1:0] bp_mask;
        logic              wp_req;
        logic [NUM_WP-1:0] wp_mask;
    } rep_t;

    rep_t rep_d, rep_q;

    always_comb begin
        rep_d.bp_req  = |bp_vec;
        rep_d.bp_mask = bp_vec;
        // fetch precedes its data access: breakpoint wins
        rep_d.wp_req  = (|wp_vec) && !(|bp_vec);
        rep_d.wp_mask = rep_d.wp_req ? wp_vec : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rep_q <= '0;
        else        rep_q <= rep_d;
    end

    assign bp_req  = rep_q.bp_req;
    assign bp_mask = rep_q.bp_mask;
    assign wp_req  = rep_q.wp_req;
    assign wp_mask = rep_q.wp_mask;
endmodule

// File: rtl/dbg_match_unit.sv
module dbg_match_unit #(
    parameter int ADDR_W = 32,
    parameter int NUM_BP = 4,
    parameter int NUM_WP = 4,
    localparam int MAXN  = (NUM_BP > NUM_WP) ? NUM_BP : NUM_WP,
    localparam int IDX_W = (MAXN > 1) ? $clog2(MAXN) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_clr,
    input  logic              cfg_wp,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [1:0]        cfg_kind,
    input  logic              fetch_vld,
    input  logic [ADDR_W-1:0] fetch_pc,
    input  logic              mem_vld,
    input  logic              mem_wr,
    input  logic [ADDR_W-1:0] mem_addr,
    output logic              mem_block,
    output logic              bp_req,
    output logic [NUM_BP-1:0] bp_mask,
    output logic              wp_req,
    output logic [NUM_WP-1:0] wp_mask
);
    logic              bp_we, wp_we;
    logic [NUM_BP-1:0] bp_vec;
    logic [NUM_WP-1:0] wp_vec;

    assign bp_we = cfg_we && !cfg_wp;
    assign wp_we = cfg_we &&  cfg_wp;

    dbg_bp_bank #(.ADDR_W(ADDR_W), .NUM(NUM_BP), .IDX_W(IDX_W)) u_bp (
        .clk(clk), .rst_n(rst_n), .wr_en(bp_we), .clr_en(cfg_clr),
        .idx(cfg_idx), .wr_addr(cfg_addr),
        .pc_vld(fetch_vld), .pc(fetch_pc), .hit_vec(bp_vec)
    );

    dbg_wp_bank #(.ADDR_W(ADDR_W), .NUM(NUM_WP), .IDX_W(IDX_W)) u_wp (
        .clk(clk), .rst_n(rst_n), .wr_en(wp_we), .clr_en(cfg_clr),
        .idx(cfg_idx), .wr_addr(cfg_addr), .wr_kind(cfg_kind),
        .acc_vld(mem_vld), .acc_wr(mem_wr), .acc_addr(mem_addr),
        .hit_vec(wp_vec)
    );

    // stop the access in the cycle it is presented
    assign mem_block = |wp_vec;

    dbg_hit_arb #(.NUM_BP(NUM_BP), .NUM_WP(NUM_WP)) u_arb (
        .clk(clk), .rst_n(rst_n), .bp_vec(bp_vec), .wp_vec(wp_vec),
        .bp_req(bp_req), .bp_mask(bp_mask), .wp_req(wp_req), .wp_mask(wp_mask)
    );
endmodule

// File: rtl/dbg_match_unit_chk.sv
module dbg_match_unit_chk #(
    parameter int NUM_BP = 4,
    parameter int NUM_WP = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fetch_vld,
    input logic              mem_vld,
    input logic              mem_block,
    input logic              bp_req,
    input logic [NUM_BP-1:0] bp_mask,
    input logic              wp_req,
    input logic [NUM_WP-1:0] wp_mask
);
    assert_block_only_on_access_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_block |-> mem_vld);

    assert_bp_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bp_req |-> !wp_req);

    assert_bp_from_fetch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bp_req |-> $past(fetch_vld));

    assert_bp_mask_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bp_req |-> ($countones(bp_mask) > 0));

    assert_wp_from_block_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wp_req |-> $past(mem_block));

    assert_wp_mask_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !wp_req |-> (wp_mask == '0));
endmodule

bind dbg_match_unit dbg_match_unit_chk #(.NUM_BP(NUM_BP), .NUM_WP(NUM_WP)) u_chk (
    .clk(clk), .rst_n(rst_n), .fetch_vld(fetch_vld), .mem_vld(mem_vld),
    .mem_block(mem_block), .bp_req(bp_req), .bp_mask(bp_mask),
    .wp_req(wp_req), .wp_mask(wp_mask)
);

// File: tb/tb_dbg_match_unit.sv
module tb_dbg_match_unit;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        cfg_we = 0, cfg_clr = 0, cfg_wp = 0;
    logic [1:0]  cfg_idx = 0;
    logic [31:0] cfg_addr = 0;
    logic [1:0]  cfg_kind = 0;
    logic        fetch_vld = 0;
    logic [31:0] fetch_pc = 0;
    logic        mem_vld = 0, mem_wr = 0;
    logic [31:0] mem_addr = 0;
    logic        mem_block, bp_req, wp_req;
    logic [3:0]  bp_mask, wp_mask;

    int checks = 0;
    int fails  = 0;

    // behavioural reference state
    bit        m_bv[4];
    int unsigned m_ba[4];
    bit        m_wv[4];
    int unsigned m_wa[4];
    int        m_wk[4];

    always #4 clk = ~clk;

    dbg_match_unit dut (.*);

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic clr_bus();
        cfg_we = 0; cfg_clr = 0; fetch_vld = 0; mem_vld = 0;
    endtask

    // one cycle: apply inputs, check comb block, advance, check registered outputs
    task automatic step(string req);
        int bpv, wpv, e_wreq, e_wmask;
        bpv = 0; wpv = 0;
        #1;
        for (int i = 0; i < 4; i++) begin
            if (fetch_vld && m_bv[i] && m_ba[i] == fetch_pc) bpv |= (1 << i);
            if (mem_vld && m_wv[i] && m_wa[i] == mem_addr &&
                ((m_wk[i] == 1 && !mem_wr) || (m_wk[i] == 2 && mem_wr) || m_wk[i] == 3))
                wpv |= (1 << i);
        end
        chk(req, "mem_block", int'(mem_block), int'(wpv != 0));
        e_wreq  = (wpv != 0 && bpv == 0) ? 1 : 0;
        e_wmask = e_wreq ? wpv : 0;
        if (cfg_we) begin
            if (!cfg_wp) begin
                if (cfg_clr) m_bv[cfg_idx] = 0;
                else begin m_bv[cfg_idx] = 1; m_ba[cfg_idx] = cfg_addr; end
            end else begin
                if (cfg_clr) begin m_wv[cfg_idx] = 0; m_wk[cfg_idx] = 0; end
                else begin
                    m_wv[cfg_idx] = (cfg_kind != 0);
                    m_wk[cfg_idx] = int'(cfg_kind);
                    m_wa[cfg_idx] = cfg_addr;
                end
            end
        end
        @(posedge clk); #1;
        chk(req, "bp_req",  int'(bp_req),  int'(bpv != 0));
        chk(req, "bp_mask", int'(bp_mask), bpv);
        chk(req, "wp_req",  int'(wp_req),  e_wreq);
        chk(req, "wp_mask", int'(wp_mask), e_wmask);
        @(negedge clk);
        clr_bus();
    endtask

    task automatic prog(bit wp, int idx, int unsigned a, int kind, string req);
        cfg_we = 1; cfg_clr = 0; cfg_wp = wp; cfg_idx = 2'(idx);
        cfg_addr = a; cfg_kind = 2'(kind);
        step(req);
    endtask

    task automatic wipe(bit wp, int idx, string req);
        cfg_we = 1; cfg_clr = 1; cfg_wp = wp; cfg_idx = 2'(idx);
        step(req);
    endtask

    task automatic fetch(int unsigned pc, string req);
        fetch_vld = 1; fetch_pc = pc; step(req);
    endtask

    task automatic access(int unsigned a, bit wr, string req);
        mem_vld = 1; mem_addr = a; mem_wr = wr; step(req);
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) begin
            m_bv[i] = 0; m_ba[i] = 0; m_wv[i] = 0; m_wa[i] = 0; m_wk[i] = 0;
        end
        repeat (3) @(negedge clk);
        #1;
        chk("R1", "bp_req in reset", int'(bp_req), 0);
        chk("R1", "wp_req in reset", int'(wp_req), 0);
        rst_n = 1;
        @(negedge clk);
        // R1: empty slots, address 0 everywhere
        fetch(32'h0, "R1");
        access(32'h0, 0, "R1");
        access(32'h0, 1, "R1");
        // R2: breakpoints
        prog(0, 0, 32'h0000_1000, 0, "R2");
        prog(0, 3, 32'h0000_2000, 0, "R2");
        fetch(32'h0000_1000, "R2");
        fetch(32'h0000_2000, "R2");
        fetch(32'h0000_1004, "R2");
        fetch_pc = 32'h0000_1000; step("R2"); // fetch_vld low
        // R3: kinds
        prog(1, 0, 32'h0000_4000, 1, "R3");
        prog(1, 1, 32'h0000_5000, 2, "R3");
        prog(1, 2, 32'h0000_6000, 3, "R3");
        access(32'h0000_4000, 0, "R3");
        access(32'h0000_4000, 1, "R3");
        access(32'h0000_5000, 0, "R3");
        access(32'h0000_5000, 1, "R3");
        access(32'h0000_6000, 0, "R3");
        access(32'h0000_6000, 1, "R3");
        // R4: disabled kind
        prog(1, 3, 32'h0000_7000, 0, "R4");
        access(32'h0000_7000, 0, "R4");
        access(32'h0000_7000, 1, "R4");
        // R5: matching address but no valid access
        mem_addr = 32'h0000_6000; mem_wr = 0; step("R5");
        // R6: exact byte compare
        access(32'h0000_4001, 0, "R6");
        access(32'h8000_4000, 0, "R6");
        fetch(32'h8000_1000, "R6");
        // R7: clear empty slot then occupied slot
        wipe(0, 1, "R7");
        fetch(32'h0000_1000, "R7");
        wipe(1, 3, "R7");
        access(32'h0000_6000, 1, "R7");
        wipe(0, 0, "R7");
        fetch(32'h0000_1000, "R7");
        // R8: simultaneous hits
        fetch_vld = 1; fetch_pc = 32'h0000_2000;
        mem_vld = 1; mem_addr = 32'h0000_6000; mem_wr = 1;
        step("R8");
        // R9: two watchpoints on one address
        prog(1, 3, 32'h0000_6000, 1, "R9");
        access(32'h0000_6000, 0, "R9");
        access(32'h0000_6000, 1, "R9");
        access(32'h0000_9000, 0, "R9");
        // R10: reprogram slots
        prog(0, 3, 32'h0000_3000, 0, "R10");
        fetch(32'h0000_2000, "R10");
        fetch(32'h0000_3000, "R10");
        prog(1, 0, 32'h0000_4000, 2, "R10");
        access(32'h0000_4000, 0, "R10");
        access(32'h0000_4000, 1, "R10");
        prog(1, 2, 32'h0000_6000, 0, "R4");
        access(32'h0000_6000, 1, "R4");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule